// File: doc/BRIEF.md
# Cache Line Burst Fill Sequencer

After an internal cache miss, this block brings one 16-byte line across a 32-bit external bus into the line buffer. It takes the missing byte address and spends one setup cycle presenting the address of the word that missed. It then collects four data beats. Each beat is written into the line buffer slot that it belongs to. The word that missed always comes back first, so a separate pulse can let execution resume before the remaining three words have arrived.

In burst mode the remaining words follow the critical word with no further setup cycles. A line from a zero-wait source therefore takes five bus cycles. In single mode every word gets its own setup cycle, which costs eight cycles per line. In either mode the external ready input can stretch any data beat. Once a fill has started, the block accepts no new miss until it has signalled that the line is complete.

Top module: `line_fill_seq`

## Requirements
- R1: After reset the block is idle. `miss_ready` is 1, and `bus_start`, `line_wr_en`, `crit_valid` and `line_done` are all 0.
- R2: A miss is taken only on a clock where both `miss_valid` and `miss_ready` are 1. While a fill is in progress, `miss_valid` and `miss_addr` have no effect on the addresses or data of the current fill.
- R3: Setup timing:
  - In the cycle after a miss is accepted, `bus_start` is 1 for exactly one cycle.
  - During that cycle `bus_addr` is the line base plus 4 times the critical word index. The critical word index is `miss_addr[3:2]`, and the line base has bits [3:0] cleared.
- R4: Beat k of a fill (k = 0..3) writes line word (c + k) mod 4, where c is the critical index. The data written is what the bus returned for that word's address.
- R5: A data beat is accepted only in a data cycle where `bus_ready` is 1. In a data cycle with `bus_ready` at 0, `line_wr_en` is 0 and `bus_addr` stays unchanged.
- R6: `crit_valid` pulses once per fill, together with the first accepted beat. `line_wr_data` then carries the critical word.
- R7: End of fill:
  - `line_done` is a one-cycle pulse in the cycle after the fourth accepted beat.
  - `miss_ready` returns to 1 in the cycle after `line_done`.
- R8: In burst mode (`burst_mode` = 1 when the miss is taken), the fill runs with no waits as one setup cycle followed by four data cycles: 5 cycles in all. Each wait cycle adds one cycle.
- R9: In single mode (`burst_mode` = 0), each of the four words gets its own setup cycle and data cycle: 8 cycles in all, plus one per wait cycle.
- R10: Throughout every setup and data cycle, `bus_addr[3:2]` selects the word being fetched. On every accepted beat it equals `line_wr_idx`.
- R11: `bus_burst` is 1 during the setup and data cycles of a burst-mode fill. It is 0 at all other times and for single-mode fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address that missed |
| burst_mode | input | 1 | 1 selects burst fill, 0 selects single-word transfers; sampled when the miss is taken |
| miss_ready | output | 1 | Sequencer idle and able to take a miss |
| bus_addr | output | 32 | External word address, valid in setup and data cycles |
| bus_start | output | 1 | Address strobe for a new bus transfer (setup cycle) |
| bus_burst | output | 1 | Current transfer is a burst |
| bus_ready | input | 1 | External data beat valid |
| bus_data | input | 32 | External data beat |
| line_wr_en | output | 1 | Write one word into the line buffer |
| line_wr_idx | output | 2 | Line buffer word slot |
| line_wr_data | output | 32 | Word to write |
| crit_valid | output | 1 | The critical word is on `line_wr_data` this cycle |
| line_done | output | 1 | Line fill complete |

## Verification
The assertions rely on the following assumptions about the inputs:
- `bus_ready` is only meaningful while the sequencer is in a data cycle.
- The external side never returns a beat before the setup cycle has been seen.
- `burst_mode` is only consulted on the clock where a miss is accepted.

The stimulus keeps within these assumptions. It raises `miss_valid` with a line address and holds it, together with the mode, until the miss is taken. From then on it answers purely from the observed `bus_addr`, with ready patterns that are either always on or hold back every second or third cycle. On some fills it keeps asserting `miss_valid` with an unrelated address while the fill is busy, to show that such requests are ignored.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } fill_state_t;

  // word slot visited on a given beat: start at the critical slot, wrap in the line
  function automatic logic [7:0] wrap_index(input logic [7:0] first,
                                            input logic [7:0] step,
                                            input logic [7:0] words);
    return (first + step) & (words - 8'd1);
  endfunction

  // byte address of a word slot inside a line
  function automatic logic [31:0] slot_byte_offset(input logic [7:0] slot,
                                                   input logic [7:0] bytes_per_word);
    return 32'(slot) * 32'(bytes_per_word);
  endfunction

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_fire,
  input  logic        burst_mode,
  input  logic        bus_ready,
  input  logic        last_beat,
  output fill_state_t state,
  output logic        burst_q
);

  fill_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (miss_fire) state_nx = ST_SETUP;
      ST_SETUP: state_nx = ST_DATA;
      ST_DATA: begin
        if (bus_ready) begin
          if (last_beat)     state_nx = ST_DONE;
          else if (!burst_q) state_nx = ST_SETUP;
          else               state_nx = ST_DATA;
        end
      end
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      burst_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (miss_fire) burst_q <= burst_mode;
    end
  end

endmodule

// File: rtl/lf_beat_cnt.sv
module lf_beat_cnt #(
  parameter int LINE_WORDS = 4,
  localparam int CNT_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] beat,
  output logic             last_beat
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_WORDS - 1);

  assign last_beat = (beat == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (clear) begin
      beat <= '0;
    end else if (advance) begin
      beat <= beat + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/lf_addr_gen.sv
module lf_addr_gen
  import lf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int BYTE_OFS  = $clog2(DATA_W / 8),
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int LINE_OFS  = BYTE_OFS + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [IDX_W-1:0]  beat,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [ADDR_W-1:0] word_addr
);

  logic [ADDR_W-LINE_OFS-1:0] base_q;
  logic [IDX_W-1:0]           crit_q;
  logic [ADDR_W-1:0]          line_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      crit_q <= '0;
    end else if (capture) begin
      base_q <= miss_addr[ADDR_W-1:LINE_OFS];
      crit_q <= miss_addr[LINE_OFS-1:BYTE_OFS];
    end
  end

  assign cur_idx   = IDX_W'(wrap_index(8'(crit_q), 8'(beat), 8'(LINE_WORDS)));
  assign line_base = {base_q, {LINE_OFS{1'b0}}};
  assign word_addr = line_base
                   + ADDR_W'(slot_byte_offset(8'(cur_idx), 8'(DATA_W / 8)));

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import lf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              burst_mode,
  output logic              miss_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_start,
  output logic              bus_burst,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_data,
  output logic              line_wr_en,
  output logic [IDX_W-1:0]  line_wr_idx,
  output logic [DATA_W-1:0] line_wr_data,
  output logic              crit_valid,
  output logic              line_done
);

  fill_state_t      state;
  logic             burst_q;
  logic             miss_fire;
  logic             in_setup;
  logic             in_data;
  logic             beat_acc;
  logic             last_beat;
  logic [IDX_W-1:0] beat;
  logic [IDX_W-1:0] cur_idx;

  // named internal events
  assign in_setup  = (state == ST_SETUP);
  assign in_data   = (state == ST_DATA);
  assign miss_fire = miss_valid && miss_ready;
  assign beat_acc  = in_data && bus_ready;

  lf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_fire  (miss_fire),
    .burst_mode (burst_mode),
    .bus_ready  (bus_ready),
    .last_beat  (last_beat),
    .state      (state),
    .burst_q    (burst_q)
  );

  lf_beat_cnt #(.LINE_WORDS(LINE_WORDS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (miss_fire),
    .advance   (beat_acc),
    .beat      (beat),
    .last_beat (last_beat)
  );

  lf_addr_gen #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (miss_fire),
    .miss_addr (miss_addr),
    .beat      (beat),
    .cur_idx   (cur_idx),
    .word_addr (bus_addr)
  );

  assign miss_ready   = (state == ST_IDLE);
  assign bus_start    = in_setup;
  assign bus_burst    = burst_q && (in_setup || in_data);
  assign line_wr_en   = beat_acc;
  assign line_wr_idx  = cur_idx;
  assign line_wr_data = bus_data;
  assign crit_valid   = beat_acc && (beat == '0);
  assign line_done    = (state == ST_DONE);

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int BYTE_OFS  = $clog2(DATA_W / 8),
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int LINE_OFS  = BYTE_OFS + IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              bus_start,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              line_wr_en,
  input logic [IDX_W-1:0]  line_wr_idx,
  input logic              crit_valid,
  input logic              line_done,
  input logic              in_data
);

  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] next_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_idx <= '0;
    else if (line_wr_en) last_idx <= line_wr_idx;
  end
  assign next_idx = last_idx + {{(IDX_W-1){1'b0}}, 1'b1};

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (bus_start && !miss_ready));

  a_r3_single_setup: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  a_r4_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wr_en && !crit_valid) |-> (line_wr_idx == next_idx));

  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !bus_ready) |=> $stable(bus_addr));

  a_r6_crit_with_beat: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> line_wr_en);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (!line_done && miss_ready));

  a_r10_addr_matches_slot: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_en |-> (bus_addr[LINE_OFS-1:BYTE_OFS] == line_wr_idx));

endmodule

bind line_fill_seq lf_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LINE_WORDS (LINE_WORDS)
) u_lf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_valid  (miss_valid),
  .miss_ready  (miss_ready),
  .bus_start   (bus_start),
  .bus_ready   (bus_ready),
  .bus_addr    (bus_addr),
  .line_wr_en  (line_wr_en),
  .line_wr_idx (line_wr_idx),
  .crit_valid  (crit_valid),
  .line_done   (line_done),
  .in_data     (in_data)
);

// File: tb/tb_line_fill_seq.sv
module tb_line_fill_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        burst_mode = 1'b1;
  logic        miss_ready;
  logic [31:0] bus_addr;
  logic        bus_start;
  logic        bus_burst;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_data = '0;
  logic        line_wr_en;
  logic [1:0]  line_wr_idx;
  logic [31:0] line_wr_data;
  logic        crit_valid;
  logic        line_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_fill_seq dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .burst_mode(burst_mode), .miss_ready(miss_ready), .bus_addr(bus_addr),
    .bus_start(bus_start), .bus_burst(bus_burst), .bus_ready(bus_ready),
    .bus_data(bus_data), .line_wr_en(line_wr_en), .line_wr_idx(line_wr_idx),
    .line_wr_data(line_wr_data), .crit_valid(crit_valid), .line_done(line_done)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 setup, 2 data, 3 done
  int          m_ph = 0;
  int          m_q[$];
  bit          m_burst = 0;
  logic [31:0] m_base = '0;
  int          m_crit = 0;
  int          m_nbeat = 0;
  int          m_cnt = 0;
  int          m_waits = 0;
  logic [31:0] got [4];

  task automatic cyc(input bit mv, input logic [31:0] ma, input bit bm, input bit rdy);
    bit e_wr;
    miss_valid = mv; miss_addr = ma; burst_mode = bm; bus_ready = rdy;
    #1;
    bus_data = memf(bus_addr);
    #1;
    e_wr = (m_ph == 2) && rdy;
    chk(miss_ready == (m_ph == 0), "R1 miss_ready", 32'(miss_ready), 32'(m_ph == 0));
    chk(bus_start == (m_ph == 1), "R3 bus_start", 32'(bus_start), 32'(m_ph == 1));
    chk(line_wr_en == e_wr, "R5 line_wr_en", 32'(line_wr_en), 32'(e_wr));
    chk(crit_valid == (e_wr && m_nbeat == 0), "R6 crit_valid", 32'(crit_valid),
        32'(e_wr && m_nbeat == 0));
    chk(line_done == (m_ph == 3), "R7 line_done", 32'(line_done), 32'(m_ph == 3));
    chk(bus_burst == (m_burst && (m_ph == 1 || m_ph == 2)), "R11 bus_burst",
        32'(bus_burst), 32'(m_burst && (m_ph == 1 || m_ph == 2)));
    if (m_ph == 1 || m_ph == 2)
      chk(bus_addr == m_base + 32'(m_q[0] * 4), "R10 bus_addr", bus_addr,
          m_base + 32'(m_q[0] * 4));
    if (e_wr && line_wr_en) begin
      chk(line_wr_idx == 2'(m_q[0]), "R4 line_wr_idx", 32'(line_wr_idx), 32'(m_q[0]));
      got[line_wr_idx] = line_wr_data;
      if (m_nbeat == 0)
        chk(line_wr_data == memf(m_base + 32'(m_crit * 4)), "R6 critical data",
            line_wr_data, memf(m_base + 32'(m_crit * 4)));
    end
    if (m_ph != 0) m_cnt++;
    if (m_ph == 2 && !rdy) m_waits++;
    if (m_ph == 3) begin
      if (m_burst)
        chk(m_cnt == 5 + m_waits + 1, "R8 burst fill cycles", 32'(m_cnt - 1),
            32'(5 + m_waits));
      else
        chk(m_cnt == 8 + m_waits + 1, "R9 single fill cycles", 32'(m_cnt - 1),
            32'(8 + m_waits));
      for (int i = 0; i < 4; i++)
        chk(got[i] == memf(m_base + 32'(i * 4)), "R4 line contents", got[i],
            memf(m_base + 32'(i * 4)));
    end
    // advance reference
    case (m_ph)
      0: if (mv) begin
           m_base = {ma[31:4], 4'b0};
           m_crit = int'(ma[3:2]);
           m_burst = bm;
           m_q.delete();
           for (int k = 0; k < 4; k++) m_q.push_back((m_crit + k) % 4);
           m_nbeat = 0; m_cnt = 0; m_waits = 0;
           for (int i = 0; i < 4; i++) got[i] = 'x;
           m_ph = 1;
         end
      1: m_ph = 2;
      2: if (rdy) begin
           void'(m_q.pop_front());
           m_nbeat++;
           if (m_q.size() == 0) m_ph = 3;
           else if (!m_burst)   m_ph = 1;
         end
      default: m_ph = 0;
    endcase
    @(posedge clk);
    #1;
  endtask

  // wp: number of not-ready cycles between ready cycles; spam: keep asking while busy (R2)
  task automatic run_fill(input logic [31:0] addr, input bit bm, input int wp, input bit spam);
    int i;
    bit rdy;
    i = 0;
    cyc(1'b1, addr, bm, 1'b0);
    while (m_ph != 0) begin
      rdy = (wp == 0) ? 1'b1 : ((i % (wp + 1)) == wp);
      cyc(spam, 32'hDEAD_BEE4 ^ 32'(i << 4), ~bm, rdy);
      i++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(miss_ready == 1'b1, "R1 reset miss_ready", 32'(miss_ready), 32'd1);
    chk(!bus_start && !line_wr_en && !crit_valid && !line_done, "R1 reset outputs",
        {28'd0, bus_start, line_wr_en, crit_valid, line_done}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R8: zero-wait bursts, every critical position (R4 wrap)
    for (int c = 0; c < 4; c++) run_fill(32'h0001_2340 | 32'(c * 4) | 32'(c), 1'b1, 0, 1'b0);
    // R9: single mode
    run_fill(32'h00AB_CD08, 1'b0, 0, 1'b0);
    run_fill(32'h00AB_CD1C, 1'b0, 0, 1'b0);
    // R5: wait states
    run_fill(32'h4000_0014, 1'b1, 1, 1'b0);
    run_fill(32'h4000_0028, 1'b1, 2, 1'b0);
    run_fill(32'h4000_003C, 1'b0, 2, 1'b0);
    // R2: requests while busy are ignored
    run_fill(32'h7777_0004, 1'b1, 0, 1'b1);
    run_fill(32'h7777_0038, 1'b0, 1, 1'b1);
    // idle cycles with no request
    repeat (3) cyc(1'b0, 32'h0, 1'b1, 1'b1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule